// File: doc/BRIEF.md
# Latchup Power-Cycle Sequencer

This block guards a circuit against single-event latchup. Two over-current flags, one from the analog supply sensor and one from the digital supply sensor, and a built-in-test request enter through two-flop synchronizers. A flag that is raised starts a decision window and drives the status output high at once. If the fault holds through the whole window, both supply switches open and the I/O transmission gates isolate the pins for a fixed off period. Power then returns, the isolation is released in the same cycle, and status clears a short time later. If the fault clears before the window ends, status drops at the end of the window and power is never touched.

A test request acts as an over-current only after it has stayed high for a qualifying time. Once qualified inside a window, the request commits that window to a power cycle. A single short pulse therefore gives exactly one cycle, and a request that stays high gives one cycle after another. After each power cycle a degraded-accuracy flag covers the functional-recovery and full-accuracy settling time. Every duration is a parameter counted in system-clock cycles.

Top module: `lp_guard`

## Requirements
- R1: A sustained fault on either the analog flag or the digital flag alone produces a power cycle, and during it both supply enables go low and return high in the same cycles.
- R2: Status rises on the third rising clock edge after a raw over-current flag is first sampled high (two synchronizer stages plus one state register), and it stays high for the whole DECIDE_CYC-cycle decision window.
- R3: If the synchronized fault is low in any cycle of the decision window and no qualified test request was seen, status falls when the window ends and both supply enables stay high throughout.
- R4: If the fault holds in every cycle of the window, both supply enables are low and the isolation output is high for exactly OFF_CYC cycles, with status high for that whole time.
- R5: The isolation output falls in the same cycle that the supply enables return high, and status stays high for another TAIL_CYC cycles before it falls.
- R6: A test request counts as a fault only after it has been high, once synchronized, for more than TEST_QUAL_CYC consecutive cycles. A shorter request leaves every output unchanged.
- R7: A qualified test request commits the current window to a power cycle even if the request is released before the window ends, so a single pulse gives exactly one power cycle.
- R8: A test request held high gives repeated power cycles, one after another.
- R9: The degraded output is high for exactly FUNC_CYC+ACC_CYC cycles, starting in the cycle that status falls after a power cycle. A window that ends without cutting power does not raise it.
- R10: A synchronous active-high reset gives supply enables high, isolation low, status low and degraded low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| oc_ana_i | input | 1 | Analog supply over-current flag (asynchronous) |
| oc_dig_i | input | 1 | Digital supply over-current flag (asynchronous) |
| test_req_i | input | 1 | Built-in-test request (asynchronous) |
| pwr_en_ana_o | output | 1 | Analog supply switch enable, high = powered |
| pwr_en_dig_o | output | 1 | Digital supply switch enable, high = powered |
| iso_en_o | output | 1 | I/O isolation enable, high = gates open |
| status_o | output | 1 | Protection-active status |
| degraded_o | output | 1 | Reduced-accuracy interval after a power cycle |

## Verification
The bench targets a fault that drops just before the decision window ends. A design that judged persistence only at the window edges would cut power here when it should not. A test pulse one cycle too short to qualify must leave status low, and a design with an off-by-one qualifier would start a window. A test pulse that is released mid-window must still give exactly one cycle: a design that re-checked the request would abort, and one that failed to clear its commit would cycle twice. The bench also checks that a held request keeps cycling, and that degraded lasts the exact settling count and never follows an aborted window.

// File: rtl/lp_guard_pkg.sv
package lp_guard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECIDE = 2'd1,
        ST_OFF    = 2'd2,
        ST_TAIL   = 2'd3
    } lp_state_e;

    typedef struct packed {
        logic oc_ana;
        logic oc_dig;
        logic test_req;
    } lp_flags_t;

    localparam int FLAG_W = $bits(lp_flags_t);

    function automatic int cnt_w(input int maxv);
        int w;
        w = $clog2(maxv + 1);
        return (w < 1) ? 1 : w;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] meta;
    logic [N-1:0] held;

    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[g] <= 1'b0;
                held[g] <= 1'b0;
            end else begin
                meta[g] <= d[g];
                held[g] <= meta[g];
            end
        end
    end

    assign q = held;
endmodule

// File: rtl/lp_test_qual.sv
module lp_test_qual
    import lp_guard_pkg::*;
#(
    parameter int QUAL_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic trip
);
    localparam int W = cnt_w(QUAL_CYC);

    logic [W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= '0;
        end else if (!req) begin
            run <= '0;
        end else if (run < W'(QUAL_CYC)) begin
            run <= run + 1'b1;
        end
    end

    assign trip = req && (run >= W'(QUAL_CYC));

    if (QUAL_CYC > 0) begin : g_chk
        // R6: a trip needs the request to have been high before
        p_trip_needs_history_r6: assert property (@(posedge clk) disable iff (rst)
            trip |-> $past(req));
    end
endmodule

// File: rtl/lp_seq.sv
module lp_seq
    import lp_guard_pkg::*;
#(
    parameter int DECIDE_CYC = 20,
    parameter int OFF_CYC    = 40,
    parameter int TAIL_CYC   = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_ana,
    input  logic oc_dig,
    input  logic trip,
    output logic pwr_on,
    output logic iso_on,
    output logic status,
    output logic tail_done
);
    localparam int MAXC = max3(DECIDE_CYC, OFF_CYC, TAIL_CYC);
    localparam int W    = cnt_w(MAXC);

    lp_state_e    st;
    logic [W-1:0] cnt;
    logic [W-1:0] lim_m1;
    logic         persist;
    logic         armed;
    logic         fault;
    logic         last;

    assign fault = oc_ana | oc_dig | trip;

    always_comb begin
        unique case (st)
            ST_DECIDE: lim_m1 = W'(DECIDE_CYC - 1);
            ST_OFF:    lim_m1 = W'(OFF_CYC - 1);
            ST_TAIL:   lim_m1 = W'(TAIL_CYC - 1);
            default:   lim_m1 = '0;
        endcase
    end

    assign last = (cnt == lim_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            persist <= 1'b0;
            armed   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (fault) begin
                        st      <= ST_DECIDE;
                        cnt     <= '0;
                        persist <= 1'b1;
                        armed   <= trip;
                    end
                end
                ST_DECIDE: begin
                    if (last) begin
                        cnt <= '0;
                        st  <= ((persist & fault) | armed | trip) ? ST_OFF : ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    persist <= persist & fault;
                    armed   <= armed | trip;
                end
                ST_OFF: begin
                    if (last) begin
                        cnt <= '0;
                        st  <= ST_TAIL;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (last) begin
                        cnt <= '0;
                        st  <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign pwr_on    = (st != ST_OFF);
    assign iso_on    = (st == ST_OFF);
    assign status    = (st != ST_IDLE);
    assign tail_done = (st == ST_TAIL) && last;

    // R2: status only rises after a fault was seen
    p_status_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> $past(fault));
    // R4: power is only cut while status is already high
    p_cut_after_status_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_on) |-> $past(status));
    // R5: isolation releases with power, status still high
    p_release_with_power_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pwr_on) |-> (!iso_on && status));
endmodule

// File: rtl/lp_recov.sv
module lp_recov
    import lp_guard_pkg::*;
#(
    parameter int RECOV_CYC = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic degraded
);
    localparam int W = cnt_w(RECOV_CYC);

    logic [W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (load) begin
            left <= W'(RECOV_CYC);
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign degraded = (left != '0);
endmodule

// File: rtl/lp_guard.sv
module lp_guard
    import lp_guard_pkg::*;
#(
    parameter int DECIDE_CYC    = 20,
    parameter int OFF_CYC       = 40,
    parameter int TAIL_CYC      = 3,
    parameter int TEST_QUAL_CYC = 5,
    parameter int FUNC_CYC      = 10,
    parameter int ACC_CYC       = 30
) (
    input  logic clk,
    input  logic rst,
    input  logic oc_ana_i,
    input  logic oc_dig_i,
    input  logic test_req_i,
    output logic pwr_en_ana_o,
    output logic pwr_en_dig_o,
    output logic iso_en_o,
    output logic status_o,
    output logic degraded_o
);
    localparam int RECOV_CYC = FUNC_CYC + ACC_CYC;
    localparam int N_SUP     = 2;

    lp_flags_t raw_f;
    lp_flags_t syn_f;
    logic      trip;
    logic      pwr_on;
    logic      tail_done;
    logic [N_SUP-1:0] sup_en;

    assign raw_f.oc_ana   = oc_ana_i;
    assign raw_f.oc_dig   = oc_dig_i;
    assign raw_f.test_req = test_req_i;

    lp_sync #(.N(FLAG_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_f),
        .q   (syn_f)
    );

    lp_test_qual #(.QUAL_CYC(TEST_QUAL_CYC)) u_qual (
        .clk  (clk),
        .rst  (rst),
        .req  (syn_f.test_req),
        .trip (trip)
    );

    lp_seq #(
        .DECIDE_CYC (DECIDE_CYC),
        .OFF_CYC    (OFF_CYC),
        .TAIL_CYC   (TAIL_CYC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .oc_ana    (syn_f.oc_ana),
        .oc_dig    (syn_f.oc_dig),
        .trip      (trip),
        .pwr_on    (pwr_on),
        .iso_on    (iso_en_o),
        .status    (status_o),
        .tail_done (tail_done)
    );

    lp_recov #(.RECOV_CYC(RECOV_CYC)) u_recov (
        .clk      (clk),
        .rst      (rst),
        .load     (tail_done),
        .degraded (degraded_o)
    );

    for (genvar s = 0; s < N_SUP; s++) begin : g_sup
        assign sup_en[s] = pwr_on;
    end

    assign pwr_en_ana_o = sup_en[0];
    assign pwr_en_dig_o = sup_en[1];

    // R9: degraded begins in the cycle after the tail ends
    p_degraded_after_tail_r9: assert property (@(posedge clk) disable iff (rst)
        $past(tail_done) |-> (degraded_o && !status_o));
endmodule

// File: tb/lp_guard_tb.sv
`timescale 1ns/1ps
module lp_guard_tb;
    localparam int DEC  = 20;
    localparam int OFFC = 40;
    localparam int TAIL = 3;
    localparam int QUAL = 5;
    localparam int FUNC = 10;
    localparam int ACC  = 30;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic oc_a = 1'b0, oc_d = 1'b0, treq = 1'b0;
    logic pa, pd, iso, stat, deg;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lp_guard #(
        .DECIDE_CYC(DEC), .OFF_CYC(OFFC), .TAIL_CYC(TAIL),
        .TEST_QUAL_CYC(QUAL), .FUNC_CYC(FUNC), .ACC_CYC(ACC)
    ) u_dut (
        .clk(clk), .rst(rst), .oc_ana_i(oc_a), .oc_dig_i(oc_d), .test_req_i(treq),
        .pwr_en_ana_o(pa), .pwr_en_dig_o(pd), .iso_en_o(iso),
        .status_o(stat), .degraded_o(deg)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model: phase 0 idle,1 window,2 off,3 tail
    bit m_valid = 0;
    bit q1a, q1d, q1b, q2a, q2d, q2b;
    int m_run, m_ph, m_cnt, m_rec;
    bit m_keep, m_commit;

    always @(posedge clk) begin
        if (rst) begin
            q1a = 0; q1d = 0; q1b = 0; q2a = 0; q2d = 0; q2b = 0;
            m_run = 0; m_ph = 0; m_cnt = 0; m_rec = 0; m_keep = 0; m_commit = 0;
            m_valid = 1;
        end else begin
            bit tq, f, endw;
            int lim;
            tq = q2b && (m_run >= QUAL);
            f  = q2a || q2d || tq;
            lim = (m_ph == 1) ? DEC : (m_ph == 2) ? OFFC : TAIL;
            endw = (m_ph != 0) && (m_cnt == lim - 1);
            if (m_ph == 3 && endw) m_rec = FUNC + ACC;
            else if (m_rec > 0) m_rec--;
            case (m_ph)
                0: if (f) begin m_ph = 1; m_cnt = 0; m_keep = 1; m_commit = tq; end
                1: begin
                    if (endw) begin
                        m_ph = ((m_keep && f) || m_commit || tq) ? 2 : 0;
                        m_cnt = 0;
                    end else m_cnt++;
                    m_keep = m_keep && f;
                    m_commit = m_commit || tq;
                end
                default: begin
                    if (endw) begin m_ph = (m_ph == 2) ? 3 : 0; m_cnt = 0; end
                    else m_cnt++;
                end
            endcase
            if (q2b) m_run = (m_run < QUAL) ? m_run + 1 : m_run; else m_run = 0;
            q2a = q1a; q2d = q1d; q2b = q1b;
            q1a = oc_a; q1d = oc_d; q1b = treq;
        end
    end

    // per-scenario observations
    int n_falls, n_off, n_deg, n_stat, n_mismatch_sup;
    bit prev_p = 1;

    always @(negedge clk) begin
        if (m_valid && !rst && !done) begin
            chk(pa == (m_ph != 2), "R4 pwr_en_ana vs model", pa, m_ph != 2);
            chk(pd == (m_ph != 2), "R1 pwr_en_dig vs model", pd, m_ph != 2);
            chk(iso == (m_ph == 2), "R5 iso vs model", iso, m_ph == 2);
            chk(stat == (m_ph != 0), "R2 status vs model", stat, m_ph != 0);
            chk(deg == (m_rec != 0), "R9 degraded vs model", deg, m_rec != 0);
            if (prev_p && !pa) n_falls++;
            if (!pa) n_off++;
            if (deg) n_deg++;
            if (stat) n_stat++;
            if (pa != pd) n_mismatch_sup++;
            prev_p = pa;
        end
    end

    task automatic clr();
        n_falls = 0; n_off = 0; n_deg = 0; n_stat = 0; n_mismatch_sup = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        cyc(3);
        #1;
        // R10: reset state
        chk(pa && pd && !iso && !stat && !deg, "R10 reset outputs",
            {pa, pd, iso, stat, deg}, 5'b11000);
        rst = 1'b0;
        cyc(2);

        // R3: analog flag held for most of the window, then released
        clr();
        oc_a = 1; cyc(DEC - 4); oc_a = 0;
        cyc(DEC + 10);
        chk(n_falls == 0, "R3 no cut on brief fault", n_falls, 0);
        chk(n_stat == DEC, "R2 status spans window", n_stat, DEC);
        chk(n_deg == 0, "R9 no degraded after abort", n_deg, 0);

        // R1/R4/R5: digital flag held through window
        clr();
        oc_d = 1; cyc(DEC + 8); oc_d = 0;
        cyc(OFFC + TAIL + FUNC + ACC + 20);
        chk(n_falls == 1, "R1 digital flag one cycle", n_falls, 1);
        chk(n_off == OFFC, "R4 off duration", n_off, OFFC);
        chk(n_stat == DEC + OFFC + TAIL, "R5 status through tail", n_stat, DEC + OFFC + TAIL);
        chk(n_deg == FUNC + ACC, "R9 degraded length", n_deg, FUNC + ACC);
        chk(n_mismatch_sup == 0, "R1 supplies together", n_mismatch_sup, 0);

        // R1: analog flag alone
        clr();
        oc_a = 1; cyc(DEC + 8); oc_a = 0;
        cyc(OFFC + TAIL + FUNC + ACC + 20);
        chk(n_falls == 1, "R1 analog flag one cycle", n_falls, 1);
        chk(n_mismatch_sup == 0, "R1 supplies together analog", n_mismatch_sup, 0);

        // R6: test pulse exactly QUAL cycles long is not enough
        clr();
        treq = 1; cyc(QUAL); treq = 0;
        cyc(DEC + 10);
        chk(n_stat == 0, "R6 short test ignored", n_stat, 0);
        chk(n_falls == 0, "R6 short test no cut", n_falls, 0);

        // R7: test pulse 2*QUAL, released well inside the window
        clr();
        treq = 1; cyc(2 * QUAL); treq = 0;
        cyc(DEC + OFFC + TAIL + FUNC + ACC + 30);
        chk(n_falls == 1, "R7 single cycle from pulse", n_falls, 1);
        chk(n_off == OFFC, "R7 pulse off duration", n_off, OFFC);

        // R8: held test request repeats
        clr();
        treq = 1; cyc(3 * (DEC + OFFC + TAIL) + 20); treq = 0;
        cyc(DEC + OFFC + TAIL + FUNC + ACC + 30);
        chk(n_falls >= 3, "R8 repeated cycles", n_falls, 3);

        // R10: reset in the middle of a power-off
        clr();
        oc_d = 1; cyc(DEC + 10); oc_d = 0;
        rst = 1; cyc(2); #1;
        chk(pa && pd && !iso && !stat && !deg, "R10 reset mid cycle",
            {pa, pd, iso, stat, deg}, 5'b11000);
        rst = 0; cyc(5);

        finish_up();
    end

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog expired t=%0t", $time);
        finish_up();
    end
endmodule